// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Core

This core turns a frequency tuning word and a phase offset word into a stream of 8-bit unsigned samples, one per clock. A 32-bit phase accumulator advances by the tuning word on every clock. The top 12 bits of the accumulator, plus the phase offset, form an address into one period of 4096 points.

Four waveshapes share that address. Sine comes from a quarter-wave table that is computed when the design is elaborated. Square, triangle and sawtooth are derived from the address bits with simple logic. A one-hot select chooses which shape drives the registered output.

The output frequency is the tuning word times the clock frequency over 2^32. A tuning word of 1 gives the finest frequency step.

Top module: `dds_wave_core`

## Requirements
- R1: The three control inputs are registered before use. The output has fixed latency from each input. A new select code appears at the output after 2 rising edges, a new phase word after 3, and a new tuning word after 4.
- R2: The 32-bit accumulator adds the registered tuning word on every clock and wraps modulo 2^32. The waveform address is (accumulator bits [31:20] + phase word) modulo 4096.
- R3: With tuning word T, the address advances by T/2^20 per clock. With T = 1, the address stays at one value for 2^20 clocks.
- R4: Sine: for address a, the sample is within 1 of 127.5 + 127.5·sin(2πa/4096).
- R5: Square: the sample is 255 for a < 2048 and 0 for a ≥ 2048.
- R6: Triangle: the sample is floor(a/8) for a < 2048, and 255 − floor((a−2048)/8) for a ≥ 2048.
- R7: Sawtooth: the sample is floor(a/16), which is the top 8 address bits.
- R8: Select codes: 4'b0001 selects sine, 4'b0010 square, 4'b0100 triangle and 4'b1000 sawtooth.
- R9: A select value that is not one-hot leaves the current shape in place. After reset the shape is sine.
- R10: While reset is asserted, the accumulator, the input registers and the sample output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | 32 | Frequency tuning word, added to the accumulator once per clock |
| phase_word | input | 12 | Phase offset in units of 2π/4096 |
| shape_sel | input | 4 | One-hot waveshape select |
| sample | output | 8 | Registered unsigned sample |

## Verification
Each control input is checked against its own delay:
- The select path has two register stages, so a new shape is due on the second rising edge.
- A phase word passes through the input register, the address register and the output register, so it is due on the third edge.
- A tuning word also passes through the accumulator, so it is due on the fourth edge.

The bench changes inputs on falling edges and reads the sample on the falling edge after the counted rising edge. This means it also checks that the old value is still present one edge early. For frequency sweeps, the bench counts edges from the reset release. The sample after edge j is expected to match the shape evaluated at address ((j−3)·T)[31:20] + P, since the accumulator starts from zero.

// File: rtl/dds_wave_pkg.sv
package dds_wave_pkg;

  typedef enum logic [3:0] {
    SHAPE_SINE   = 4'b0001,
    SHAPE_SQUARE = 4'b0010,
    SHAPE_TRI    = 4'b0100,
    SHAPE_SAW    = 4'b1000
  } shape_e;

  // pi scaled by 2^30, used for the fixed-point series below
  localparam longint PI_Q30 = 64'sd3373259426;

  // Magnitude of the sine over the first quarter period.
  // k runs 0..qsize; the result is floor(sin(k*pi/(2*qsize)) * (2^samp_w-1)/2).
  function automatic int quarter_sine_mag(input int k, input int qsize, input int samp_w);
    longint x;
    longint t;
    longint sum;
    longint mag;
    longint lim;
    x   = (longint'(k) * PI_Q30) / longint'(2 * qsize);
    t   = x;
    sum = x;
    for (int n = 1; n <= 6; n++) begin
      t   = (t * x) >>> 30;
      t   = (t * x) >>> 30;
      t   = -(t / longint'((2 * n) * (2 * n + 1)));
      sum = sum + t;
    end
    mag = (sum * ((longint'(1) <<< samp_w) - 1)) >>> 31;
    lim = (longint'(1) <<< (samp_w - 1)) - 1;
    if (mag > lim) mag = lim;
    if (mag < 0) mag = 0;
    return int'(mag);
  endfunction

endpackage

// File: rtl/dds_in_regs.sv
module dds_in_regs
  import dds_wave_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  tune_in,
  input  logic [ADDR_W-1:0] phase_in,
  input  logic [3:0]        shape_in,
  output logic [ACC_W-1:0]  tune_q,
  output logic [ADDR_W-1:0] phase_q,
  output shape_e            sel_q
);

  logic sel_en;

  // Load the select register only when exactly one bit of shape_in is set.
  always_comb begin
    sel_en = (shape_in != 4'd0) && ((shape_in & (shape_in - 4'd1)) == 4'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q  <= '0;
      phase_q <= '0;
      sel_q   <= SHAPE_SINE;
    end else begin
      tune_q  <= tune_in;
      phase_q <= phase_in;
      if (sel_en) begin
        sel_q <= shape_e'(shape_in);
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(sel_q)); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$onehot(shape_in) |=> $stable(sel_q)); // R9

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  tune_q,
  input  logic [ADDR_W-1:0] phase_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    acc_d  = acc_q + tune_q;
    addr_d = acc_q[ACC_W-1 -: ADDR_W] + phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      addr_q <= '0;
    end else begin
      acc_q  <= acc_d;
      addr_q <= addr_d;
    end
  end

  AST_ACC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (tune_q == '0) |=> $stable(acc_q)); // R2
  AST_ADDR_STILL: assert property (@(posedge clk) disable iff (!rst_n) ($stable(acc_q) && $stable(phase_q)) |=> $stable(addr_q)); // R2

endmodule

// File: rtl/dds_shape_gen.sv
module dds_shape_gen
  import dds_wave_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  shape_e            sel,
  output logic [SAMP_W-1:0] sample_q
);

  localparam int QSIZE  = 1 << (ADDR_W - 2);
  localparam int HALF_W = ADDR_W - 1;
  localparam int MAG_W  = SAMP_W - 1;
  localparam int MID    = 1 << (SAMP_W - 1);

  logic [MAG_W-1:0] qtab [QSIZE+1];

  // Quarter-wave sine table, filled from the package function at elaboration.
  for (genvar k = 0; k <= QSIZE; k++) begin : g_qtab
    assign qtab[k] = MAG_W'(quarter_sine_mag(k, QSIZE, SAMP_W));
  end

  logic [HALF_W-1:0] half_pos;
  logic [HALF_W-1:0] qidx;
  logic [MAG_W-1:0]  mag;
  logic [SAMP_W-1:0] sine_v;
  logic [SAMP_W-1:0] square_v;
  logic [SAMP_W-1:0] tri_base;
  logic [SAMP_W-1:0] tri_v;
  logic [SAMP_W-1:0] saw_v;
  logic [SAMP_W-1:0] sample_d;

  always_comb begin
    // Fold the position within the half period onto the quarter table.
    half_pos = addr[HALF_W-1:0];
    qidx     = half_pos[HALF_W-1] ? (~half_pos + 1'b1) : half_pos;
    mag      = qtab[qidx];
    // Upper half of the code range for the first half period, mirrored below it for the second.
    sine_v   = addr[ADDR_W-1] ? (SAMP_W'(MID - 1) - {1'b0, mag})
                              : (SAMP_W'(MID) + {1'b0, mag});
    square_v = addr[ADDR_W-1] ? '0 : '1;
    tri_base = addr[ADDR_W-2 -: SAMP_W];
    tri_v    = addr[ADDR_W-1] ? ~tri_base : tri_base;
    saw_v    = addr[ADDR_W-1 -: SAMP_W];
  end

  always_comb begin
    unique case (sel)
      SHAPE_SQUARE: sample_d = square_v;
      SHAPE_TRI:    sample_d = tri_v;
      SHAPE_SAW:    sample_d = saw_v;
      default:      sample_d = sine_v;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
    end else begin
      sample_q <= sample_d;
    end
  end

  AST_SQUARE_RAIL: assert property (@(posedge clk) disable iff (!rst_n) (sel == SHAPE_SQUARE) |=> (sample_q == '0 || sample_q == '1)); // R5
  AST_SAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (sel == SHAPE_SAW && addr == '0) |=> (sample_q == '0)); // R7

endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core
  import dds_wave_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  tune_word,
  input  logic [ADDR_W-1:0] phase_word,
  input  logic [3:0]        shape_sel,
  output logic [SAMP_W-1:0] sample
);

  logic [ACC_W-1:0]  tune_q;
  logic [ADDR_W-1:0] phase_q;
  shape_e            sel_q;
  logic [ADDR_W-1:0] addr_q;

  dds_in_regs #(
    .ACC_W (ACC_W),
    .ADDR_W(ADDR_W)
  ) u_in_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .tune_in (tune_word),
    .phase_in(phase_word),
    .shape_in(shape_sel),
    .tune_q  (tune_q),
    .phase_q (phase_q),
    .sel_q   (sel_q)
  );

  dds_phase_acc #(
    .ACC_W (ACC_W),
    .ADDR_W(ADDR_W)
  ) u_phase_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tune_q (tune_q),
    .phase_q(phase_q),
    .addr_q (addr_q)
  );

  dds_shape_gen #(
    .ADDR_W(ADDR_W),
    .SAMP_W(SAMP_W)
  ) u_shape_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr_q),
    .sel     (sel_q),
    .sample_q(sample)
  );

  AST_SEL_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n) (shape_sel == 4'b0010) |=> ##1 (sample == '0 || sample == '1)); // R1

endmodule

// File: tb/dds_wave_core_test.sv
module dds_wave_core_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] tune_word;
  logic [11:0] phase_word;
  logic [3:0]  shape_sel;
  logic [7:0]  sample;

  int checks = 0;
  int fails  = 0;

  dds_wave_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tune_word (tune_word),
    .phase_word(phase_word),
    .shape_sel (shape_sel),
    .sample    (sample)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_sine(input string req, input int act, input int a);
    real v;
    real d;
    v = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * real'(a) / 4096.0);
    d = real'(act) - v;
    checks++;
    if (d > 1.0 || d < -1.0) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0f (addr %0d)", req, act, v, a);
    end
  endtask

  function automatic int shape_ref(input logic [3:0] sel, input int a);
    case (sel)
      4'b0010: return (a < 2048) ? 255 : 0;
      4'b0100: return (a < 2048) ? (a / 8) : (255 - (a - 2048) / 8);
      default: return a / 16;
    endcase
  endfunction

  task automatic check_shape(input string req, input logic [3:0] sel, input int a);
    if (sel == 4'b0001) check_sine(req, int'(sample), a);
    else check_eq(req, int'(sample), shape_ref(sel, a));
  endtask

  // Reset with zero words; reset is released on a falling edge, so the next rising edge is edge 1.
  task automatic do_reset(input logic [3:0] sel);
    @(negedge clk);
    rst_n      = 1'b0;
    tune_word  = '0;
    phase_word = '0;
    shape_sel  = sel;
    repeat (3) @(negedge clk);
    check_eq("R10 reset output", int'(sample), 0);
    rst_n = 1'b1;
  endtask

  // Sample after edge j equals shape at ((j-3)*T)[31:20] + P.
  task automatic run_sweep(input string req, input logic [3:0] sel, input logic [31:0] t,
                           input logic [11:0] p, input int ncyc);
    do_reset(4'b0001);
    tune_word  = t;
    phase_word = p;
    shape_sel  = sel;
    for (int j = 1; j <= ncyc + 2; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        logic [31:0] acc_e;
        logic [11:0] a;
        acc_e = 32'(j - 3) * t;
        a     = acc_e[31:20] + p;
        check_shape(req, sel, int'(a));
      end
    end
  endtask

  task automatic t_reset_default();
    do_reset(4'b0000);
    repeat (4) @(negedge clk);
    check_sine("R9 default sine with invalid select", int'(sample), 0);
    check_sine("R10 cleared accumulator gives address 0", int'(sample), 0);
  endtask

  task automatic t_select();
    do_reset(4'b0001);
    phase_word = 12'd700;
    repeat (3) @(negedge clk);
    check_sine("R8 sine code", int'(sample), 700);
    shape_sel = 4'b0010;
    @(negedge clk);
    check_sine("R1 select not yet at edge 1", int'(sample), 700);
    @(negedge clk);
    check_eq("R8 square code", int'(sample), 255);
    shape_sel = 4'b0110;
    repeat (2) @(negedge clk);
    check_eq("R9 two-hot select ignored", int'(sample), 255);
    shape_sel = 4'b0000;
    repeat (2) @(negedge clk);
    check_eq("R9 zero select ignored", int'(sample), 255);
    shape_sel = 4'b0100;
    repeat (2) @(negedge clk);
    check_eq("R8 triangle code", int'(sample), 87);
    shape_sel = 4'b1000;
    repeat (2) @(negedge clk);
    check_eq("R8 sawtooth code", int'(sample), 43);
    shape_sel = 4'b1100;
    repeat (2) @(negedge clk);
    check_eq("R9 two-hot select ignored after saw", int'(sample), 43);
  endtask

  task automatic t_latency();
    do_reset(4'b1000);
    phase_word = 12'd100;
    repeat (3) @(negedge clk);
    check_eq("R1 phase settled", int'(sample), 6);
    phase_word = 12'd900;
    @(negedge clk);
    check_eq("R1 phase edge 1 old", int'(sample), 6);
    @(negedge clk);
    check_eq("R1 phase edge 2 old", int'(sample), 6);
    @(negedge clk);
    check_eq("R1 phase edge 3 new", int'(sample), 56);
    tune_word = 32'h4000_0000;
    repeat (3) @(negedge clk);
    check_eq("R1 tune edge 3 old", int'(sample), 56);
    @(negedge clk);
    check_eq("R1 tune edge 4 new", int'(sample), 120);
  endtask

  initial begin
    rst_n      = 1'b0;
    tune_word  = '0;
    phase_word = '0;
    shape_sel  = 4'b0001;
    t_reset_default();
    run_sweep("R4 sine sweep", 4'b0001, 32'h0150_0000, 12'd0, 200);
    run_sweep("R5 square sweep", 4'b0010, 32'h0070_0000, 12'd100, 100);
    run_sweep("R6 triangle sweep", 4'b0100, 32'h00B0_0000, 12'd2000, 100);
    run_sweep("R7 sawtooth reverse sweep R2 wrap", 4'b1000, 32'hFFF0_0000, 12'd5, 100);
    run_sweep("R3 tuning word 1 holds address", 4'b1000, 32'h0000_0001, 12'd0, 3000);
    run_sweep("R3 slow triangle step", 4'b0100, 32'h0002_0000, 12'd0, 2000);
    run_sweep("R2 phase offset wraps", 4'b1000, 32'h0010_0000, 12'd4000, 150);
    t_select();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule